// File: doc/BRIEF.md
# Multi-Channel Down-Counter Timer Bank

This block groups two or three down-counting timer channels behind one word-addressed register port. A shared start register holds one run bit per channel. Each channel has a reload value, a live count, a control word with a prescale choice, an interrupt enable and an underflow flag, and its own interrupt output. A free-running prescaler is shared by all channels and offers five tick rates. An optional one-bit output-control register drives a pin.

The address map is uneven. Channels 0 and 1 each get a three-word window. Channel 2 gets a four-word window that adds a plain capture holding register. Parameters choose whether channel 2 and the output-control register exist. Accesses that hit no register return zero and raise a sticky error output.

Top module: `tmr_bank`

## Requirements
- R1: After reset, the start register, the output-control register, every control word and every underflow flag are 0. Every reload and count register is all ones. The error output and all interrupt lines are low.
- R2: Word addresses map as follows: 0 is output control, 1 is start, 2/3/4 are channel 0 reload/count/control, 5/6/7 are the same for channel 1, and 8/9/10/11 are channel 2 reload/count/control/capture. Read data appears on `bus_rdata` the cycle after `bus_rd` and holds until the next read. A read and a write in the same cycle return the old value.
- R3: Start bit k runs channel k. Clearing the bit freezes that channel's count, and setting it again resumes from the frozen value.
- R4: Control bits [2:0] select the prescale. A value s from 0 to 4 gives a tick whenever the prescaler (0 at reset, +1 each cycle) modulo 4^(s+1) equals 4^(s+1)-1. Values 5 to 7 never tick. A running channel decrements once per tick.
- R5: A tick taken at count 0 loads the reload value and sets the underflow flag, which reads back at control bit 8.
- R6: Writing control with bit 8 = 0 clears the flag, and bit 8 = 1 leaves it unchanged. An underflow in the same cycle wins over the clear.
- R7: `irq[k]` is high exactly while channel k's flag and its enable (control bit 5) are both set.
- R8: A count write takes effect the next cycle and wins over a tick. A reload write never changes the count.
- R9: A read or write of an address with no register sets the sticky `bus_err`. Such a read returns 0, and such a write changes no state.
- R10: With channel 2 absent, addresses 8 and above are unmapped, and writing start bit 2 as 1 sets `bus_err` while bit 2 stays 0. With output control absent, address 0 is unmapped.
- R11: `outctl` equals bit 0 of the last value written to the output-control register, and that register reads back only bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | AW | Word address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| bus_err | output | 1 | Sticky access error |
| outctl | output | 1 | Output-control bit |
| irq | output | 3 | Per-channel interrupt; bit 2 low when channel 2 is absent |

## Verification
A wrong count or a wrong prescaler phase shifts the time at which a channel's interrupt rises. The bench model tracks each channel's counter and each tick exactly, so such a fault shows as an `irq` mismatch within one underflow period. At the fastest rate with small reload values, that period is a few dozen cycles. A broken decode or flag update shows on `bus_rdata` one cycle after the next read of the affected word, or on `bus_err` at the edge after the access.

// File: rtl/tmr_bank_pkg.sv
package tmr_bank_pkg;
   // Register index inside a channel window.
   localparam logic [1:0] IDX_RELOAD = 2'd0;
   localparam logic [1:0] IDX_COUNT  = 2'd1;
   localparam logic [1:0] IDX_CTRL   = 2'd2;
   localparam logic [1:0] IDX_CAPT   = 2'd3;

   // Control word bit positions.
   localparam int CTL_SEL_W = 3;
   localparam int CTL_IE    = 5;
   localparam int CTL_FLAG  = 8;

   localparam int ADR_OUTCTL = 0;
   localparam int ADR_START  = 1;
   localparam int MAX_CH     = 3;

   function automatic int chan_base(input int k);
      return (k == 0) ? 2 : (k == 1) ? 5 : 8;
   endfunction

   function automatic int chan_nregs(input int k);
      return (k == 2) ? 4 : 3;
   endfunction
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
   parameter int NSEL = 5
) (
   input  logic            clk,
   input  logic            rst_n,
   output logic [NSEL-1:0] tick
);
   localparam int PW = 2 * NSEL;

   logic [PW-1:0] pre_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pre_q <= '0;
      else        pre_q <= pre_q + 1'b1;
   end

   for (genvar i = 0; i < NSEL; i++) begin : g_tick
      assign tick[i] = &pre_q[2*i+1:0];
   end
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
   import tmr_bank_pkg::*;
#(
   parameter int CW      = 32,
   parameter int NSEL    = 5,
   parameter bit HAS_CAP = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            run,
   input  logic [NSEL-1:0] tick,
   input  logic            acc_wr,
   input  logic [1:0]      acc_idx,
   input  logic [31:0]     wdata,
   output logic [31:0]     rdata,
   output logic            irq
);
   logic [CW-1:0]        reload_q, cnt_q;
   logic [CTL_SEL_W-1:0] sel_q;
   logic                 ie_q, flag_q;
   logic [31:0]          cap_q;
   logic                 sel_tick, step, under;
   logic                 wr_rel, wr_cnt, wr_ctl;

   always_comb begin
      sel_tick = 1'b0;
      for (int i = 0; i < NSEL; i++)
         if (int'(sel_q) == i) sel_tick = tick[i];
   end

   assign step   = run && sel_tick;
   assign under  = step && (cnt_q == '0);
   assign wr_rel = acc_wr && (acc_idx == IDX_RELOAD);
   assign wr_cnt = acc_wr && (acc_idx == IDX_COUNT);
   assign wr_ctl = acc_wr && (acc_idx == IDX_CTRL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reload_q <= '1;
         cnt_q    <= '1;
         sel_q    <= '0;
         ie_q     <= 1'b0;
         flag_q   <= 1'b0;
      end else begin
         if (wr_rel) reload_q <= wdata[CW-1:0];
         if (wr_cnt)     cnt_q <= wdata[CW-1:0];
         else if (under) cnt_q <= reload_q;
         else if (step)  cnt_q <= cnt_q - 1'b1;
         if (wr_ctl) begin
            sel_q <= wdata[CTL_SEL_W-1:0];
            ie_q  <= wdata[CTL_IE];
         end
         if (under)                         flag_q <= 1'b1;
         else if (wr_ctl && !wdata[CTL_FLAG]) flag_q <= 1'b0;
      end
   end

   if (HAS_CAP) begin : g_cap
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                               cap_q <= '0;
         else if (acc_wr && acc_idx == IDX_CAPT)   cap_q <= wdata;
      end
   end else begin : g_nocap
      assign cap_q = '0;
   end

   always_comb begin
      rdata = '0;
      case (acc_idx)
         IDX_RELOAD: rdata[CW-1:0] = reload_q;
         IDX_COUNT:  rdata[CW-1:0] = cnt_q;
         IDX_CTRL: begin
            rdata[CTL_SEL_W-1:0] = sel_q;
            rdata[CTL_IE]        = ie_q;
            rdata[CTL_FLAG]      = flag_q;
         end
         default:    rdata = cap_q;
      endcase
   end

   assign irq = flag_q && ie_q;

   a_r3_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !wr_cnt) |=> $stable(cnt_q));
   a_r5_reload_on_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (step && cnt_q == '0 && !wr_cnt) |=> (cnt_q == $past(reload_q) && flag_q));
   a_r6_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctl && !wdata[CTL_FLAG] && !under) |=> !flag_q);
   a_r8_count_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
      wr_cnt |=> cnt_q == $past(wdata[CW-1:0]));
endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
   import tmr_bank_pkg::*;
#(
   parameter int AW      = 6,
   parameter int CW      = 32,
   parameter int NSEL    = 5,
   parameter bit HAS_CH2 = 1'b1,
   parameter bit HAS_OCR = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] bus_addr,
   input  logic          bus_wr,
   input  logic [31:0]   bus_wdata,
   input  logic          bus_rd,
   output logic [31:0]   bus_rdata,
   output logic          bus_err,
   output logic          outctl,
   output logic [2:0]    irq
);
   localparam int NCH = HAS_CH2 ? 3 : 2;

   if (CW < 1 || CW > 32) begin : g_bad_cw
      $error("tmr_bank: CW must lie in 1..32");
   end
   if (NSEL < 1 || NSEL > 8) begin : g_bad_nsel
      $error("tmr_bank: NSEL must lie in 1..8");
   end
   if (AW < 4) begin : g_bad_aw
      $error("tmr_bank: AW too small for the map");
   end

   logic [NSEL-1:0] tick;
   logic [2:0]      start_q;
   logic            ocr_q;
   logic            ocr_hit, start_hit, any_hit;
   logic [MAX_CH-1:0] ch_hit;
   logic [31:0]     ch_rd [MAX_CH];
   logic [31:0]     rd_mux;
   int              adr;

   assign adr       = int'(bus_addr);
   assign ocr_hit   = HAS_OCR && (adr == ADR_OUTCTL);
   assign start_hit = (adr == ADR_START);

   tmr_prescale #(.NSEL(NSEL)) pre_i (
      .clk(clk), .rst_n(rst_n), .tick(tick)
   );

   for (genvar k = 0; k < MAX_CH; k++) begin : g_ch
      localparam int BASE = chan_base(k);
      localparam int NREG = chan_nregs(k);
      if (k < NCH) begin : g_on
         logic [1:0] idx;
         assign ch_hit[k] = (adr >= BASE) && (adr < BASE + NREG);
         assign idx       = 2'(adr - BASE);
         tmr_chan #(.CW(CW), .NSEL(NSEL), .HAS_CAP(k == 2)) chan_i (
            .clk(clk), .rst_n(rst_n), .run(start_q[k]), .tick(tick),
            .acc_wr(bus_wr && ch_hit[k]), .acc_idx(idx), .wdata(bus_wdata),
            .rdata(ch_rd[k]), .irq(irq[k])
         );
      end else begin : g_off
         assign ch_hit[k] = 1'b0;
         assign ch_rd[k]  = '0;
         assign irq[k]    = 1'b0;
      end
   end

   assign any_hit = ocr_hit || start_hit || (|ch_hit);

   always_comb begin
      rd_mux = '0;
      if (ocr_hit)   rd_mux[0]   = ocr_q;
      if (start_hit) rd_mux[2:0] = start_q;
      for (int k = 0; k < MAX_CH; k++)
         if (ch_hit[k]) rd_mux = ch_rd[k];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_q   <= '0;
         ocr_q     <= 1'b0;
         bus_err   <= 1'b0;
         bus_rdata <= '0;
      end else begin
         if (bus_rd) bus_rdata <= rd_mux;
         if (bus_wr && start_hit)
            start_q <= {HAS_CH2 ? bus_wdata[2] : 1'b0, bus_wdata[1:0]};
         if (bus_wr && ocr_hit) ocr_q <= bus_wdata[0];
         if (((bus_rd || bus_wr) && !any_hit) ||
             (!HAS_CH2 && bus_wr && start_hit && bus_wdata[2]))
            bus_err <= 1'b1;
      end
   end

   assign outctl = ocr_q;

   a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      bus_err |=> bus_err);
   a_r2_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> $stable(bus_rdata));
   a_r9_miss_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && !any_hit) |=> (bus_rdata == '0 && bus_err));
   a_r11_outctl_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && ocr_hit) |=> outctl == $past(bus_wdata[0]));
endmodule

// File: tb/tmr_bank_tb_top.sv
`timescale 1ns/1ps
module tmr_bank_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic [5:0]  bus_addr = '0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        bus_err, outctl;
   logic [2:0]  irq;

   logic [5:0]  b2_addr = '0;
   logic        b2_wr = 1'b0, b2_rd = 1'b0;
   logic [31:0] b2_wdata = '0;
   logic [31:0] b2_rdata;
   logic        b2_err, b2_outctl;
   logic [2:0]  b2_irq;

   tmr_bank dut_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
      .bus_err(bus_err), .outctl(outctl), .irq(irq)
   );

   tmr_bank #(.HAS_CH2(1'b0), .HAS_OCR(1'b0)) dut2_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(b2_addr), .bus_wr(b2_wr),
      .bus_wdata(b2_wdata), .bus_rd(b2_rd), .bus_rdata(b2_rdata),
      .bus_err(b2_err), .outctl(b2_outctl), .irq(b2_irq)
   );

   int n_cmp = 0, n_bad = 0;
   bit finished = 1'b0;

   // ---------------- behavioural reference ----------------
   longint      m_pre;
   logic        m_ocr, m_err;
   logic [2:0]  m_start;
   logic [31:0] m_rel [3], m_cnt [3], m_cap, m_rdata;
   logic [2:0]  m_sel [3];
   logic        m_ie [3], m_flag [3];

   task automatic m_reset();
      m_pre = 0; m_ocr = 0; m_err = 0; m_start = 0; m_cap = 0; m_rdata = 0;
      for (int k = 0; k < 3; k++) begin
         m_rel[k] = '1; m_cnt[k] = '1; m_sel[k] = 0; m_ie[k] = 0; m_flag[k] = 0;
      end
   endtask

   function automatic logic [31:0] m_read(input int a);
      int k, r;
      if (a == 0) return {31'd0, m_ocr};
      if (a == 1) return {29'd0, m_start};
      if (a == 11) return m_cap;
      if (a < 2 || a > 10) return 0;
      k = (a < 5) ? 0 : (a < 8) ? 1 : 2;
      r = a - ((k == 0) ? 2 : (k == 1) ? 5 : 8);
      if (r == 0) return m_rel[k];
      if (r == 1) return m_cnt[k];
      return (32'(m_flag[k]) << 8) | (32'(m_ie[k]) << 5) | 32'(m_sel[k]);
   endfunction

   initial m_reset();

   always @(posedge clk) begin
      if (!rst_n) m_reset();
      else begin
         int a;
         logic [31:0] ncnt [3];
         logic nflag [3];
         a = int'(bus_addr);
         if (bus_rd) m_rdata = m_read(a);
         if ((bus_rd || bus_wr) && a > 11) m_err = 1;
         for (int k = 0; k < 3; k++) begin
            int base;
            longint d;
            logic tk, und;
            base = (k == 0) ? 2 : (k == 1) ? 5 : 8;
            d  = 64'd4 << (2 * m_sel[k]);
            tk = m_start[k] && (m_sel[k] < 5) && ((m_pre % d) == d - 1);
            und = tk && (m_cnt[k] == 0);
            ncnt[k]  = (bus_wr && a == base + 1) ? bus_wdata :
                       und ? m_rel[k] : tk ? m_cnt[k] - 1 : m_cnt[k];
            nflag[k] = und ? 1'b1 :
                       (bus_wr && a == base + 2 && !bus_wdata[8]) ? 1'b0 : m_flag[k];
            if (bus_wr && a == base + 2) begin
               m_sel[k] = bus_wdata[2:0]; m_ie[k] = bus_wdata[5];
            end
            if (bus_wr && a == base) m_rel[k] = bus_wdata;
         end
         for (int k = 0; k < 3; k++) begin
            m_cnt[k] = ncnt[k]; m_flag[k] = nflag[k];
         end
         if (bus_wr && a == 0) m_ocr = bus_wdata[0];
         if (bus_wr && a == 1) m_start = bus_wdata[2:0];
         if (bus_wr && a == 11) m_cap = bus_wdata;
         m_pre++;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   // Every-cycle comparison against the model.
   always @(negedge clk) begin
      if (rst_n) begin
         chk("R7 irq", {29'd0, irq},
             {29'd0, m_flag[2] & m_ie[2], m_flag[1] & m_ie[1], m_flag[0] & m_ie[0]});
         chk("R2 rdata", bus_rdata, m_rdata);
         chk("R9 err", {31'd0, bus_err}, {31'd0, m_err});
         chk("R11 outctl", {31'd0, outctl}, {31'd0, m_ocr});
      end
   end

   // ---------------- bus tasks ----------------
   task automatic bw(input int a, input logic [31:0] d);
      @(negedge clk); bus_addr = 6'(a); bus_wdata = d; bus_wr = 1;
      @(negedge clk); bus_wr = 0;
   endtask

   task automatic br(input int a, output logic [31:0] v);
      @(negedge clk); bus_addr = 6'(a); bus_rd = 1;
      @(negedge clk); bus_rd = 0; v = bus_rdata;
   endtask

   task automatic b2w(input int a, input logic [31:0] d);
      @(negedge clk); b2_addr = 6'(a); b2_wdata = d; b2_wr = 1;
      @(negedge clk); b2_wr = 0;
   endtask

   task automatic b2r(input int a, output logic [31:0] v);
      @(negedge clk); b2_addr = 6'(a); b2_rd = 1;
      @(negedge clk); b2_rd = 0; v = b2_rdata;
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      #2_000_000;
      if (!finished) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] v, v1;
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1 reset state
      chk("R1 irq", {29'd0, irq}, 0);
      chk("R1 err", {31'd0, bus_err}, 0);
      br(1, v); chk("R1 start", v, 0);
      br(3, v); chk("R1 count", v, 32'hFFFF_FFFF);
      br(10, v); chk("R1 ctrl2", v, 0);
      // R11 output control keeps bit 0 only
      bw(0, 32'hFFFF_FFFF);
      br(0, v); chk("R11 readback", v, 1);
      // ch0 fast underflow, R4 R5 R6 R7
      bw(2, 3); bw(3, 3); bw(4, 32'h20); bw(1, 1);
      wait_cyc(40);
      br(4, v); chk("R5 flag set", v, 32'h120);
      bw(4, 32'h120); br(4, v1);
      chk("R6 write 1 keeps flag", v1 & 32'h100, 32'h100);
      // R3 pause holds count
      bw(1, 0); br(3, v); wait_cyc(20); br(3, v1);
      chk("R3 paused count", v1, v);
      // R8 reload write leaves count; count write lands
      bw(2, 9); br(3, v1); chk("R8 reload no effect", v1, v);
      bw(3, 7); br(3, v1); chk("R8 count write", v1, 7);
      bw(1, 1); wait_cyc(30);
      // ch1 at /16
      bw(5, 1); bw(6, 1); bw(7, 32'h21); bw(1, 3);
      wait_cyc(100);
      // ch2: capture storage and a never-ticking select (R4)
      bw(11, 32'hDEAD_0001); br(11, v); chk("R2 capture", v, 32'hDEAD_0001);
      bw(9, 5); bw(10, 32'h27); bw(1, 7);
      wait_cyc(50);
      br(9, v); chk("R4 select 7 no tick", v, 5);
      // R9 unmapped
      br(12, v); chk("R9 miss reads 0", v, 0);
      chk("R9 err set", {31'd0, bus_err}, 1);
      bw(40, 32'h1234); br(0, v); chk("R9 miss write no effect", v, 1);
      // random traffic, model compares each cycle
      for (int i = 0; i < 400; i++) begin
         int a;
         logic [31:0] d;
         a = $urandom_range(0, 13);
         case (a)
            1: d = $urandom_range(0, 7);
            4, 7, 10: d = (32'($urandom_range(0, 1)) << 8) |
                          (32'($urandom_range(0, 1)) << 5) | 32'($urandom_range(0, 7));
            default: d = $urandom_range(0, 7);
         endcase
         if ($urandom_range(0, 1) == 1) bw(a, d);
         else br(a, v);
         wait_cyc($urandom_range(0, 6));
      end
      // R10 reduced configuration
      chk("R10 err clear", {31'd0, b2_err}, 0);
      b2w(1, 32'h7); wait_cyc(1);
      chk("R10 bit2 write err", {31'd0, b2_err}, 1);
      b2r(1, v); chk("R10 bit2 stays 0", v, 3);
      b2r(8, v); chk("R10 ch2 absent", v, 0);
      b2r(0, v); chk("R10 outctl absent", v, 0);
      chk("R10 outctl pin", {31'd0, b2_outctl}, 0);
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule